// File: doc/BRIEF.md
# Storage Device Reset Sequencer

This block is the device-side controller that a serial storage target uses to bring itself out of reset and to carry out the two housekeeping commands that end in a register status report: the device-reset command and the run-diagnostics command. It watches a hardware reset indication, its release, the software-reset bit of received control frames and single-cycle command strobes. It drives a small self-test engine, a halt strobe towards the command queue and a status-frame request towards a transmit stub. The block never encodes a frame itself. It presents a status byte and an error byte and holds them while it waits for the transmit stub to accept them.

A hardware reset wins over everything else. The sequencer then waits for the reset to be released, runs the self-test, and reports pass or fail before it hands control back to the idle dispatcher. A software-reset frame pre-empts any command in flight. The sequencer then waits for a frame with the bit clear, halts outstanding work, and reports. The device-reset command halts outstanding work and waits for the queue to go quiet. If the queue does not settle within a bounded number of cycles, the status reported is bad.

Top module: `dev_reset_seq`

## Requirements
- R1: While `rst` is high and after it falls, the block is held in the reset-wait state, and `test_run`, `halt_strobe`, `tx_req` and `idle_ret` are all 0.
- R2: A high `hw_rst_on` at a clock edge, whatever the block is doing, puts it in the reset-wait state at that edge. From the next cycle `test_run`, `tx_req` and `halt_strobe` are 0.
- R3: In the reset-wait state, commands and software-reset frames have no effect. The only exit is `hw_rst_off`, and `test_run` goes high in the cycle after it is sampled.
- R4: `test_run` stays high until `st_done` is sampled. In the next cycle `tx_req` rises with good status if `st_pass` was 1, and with bad status otherwise.
- R5: The status encoding is as follows. Busy is `tx_stat[7]` and is always 0. Error is `tx_stat[0]`. Good status is `tx_stat`=8'h50 with `tx_err`=8'h01. Bad status is `tx_stat`=8'h51 with `tx_err`=8'h80.
- R6: `tx_req`, `tx_stat` and `tx_err` hold steady until `tx_ack` is sampled. In the next cycle `tx_req` is 0 and `idle_ret` is high for exactly one cycle.
- R7: A `cmd_diag` strobe sampled in idle makes `test_run` high in the next cycle. If it coincides with `cmd_devrst`, the diagnostics command wins.
- R8: A `cmd_devrst` strobe sampled in idle gives a one-cycle `halt_strobe` in the next cycle. If `quiet` is high at the k-th halt edge (counting from 0), good status is requested after that edge.
- R9: If `quiet` stays low for HALT_LIMIT halt edges, the halt ends with bad status after edge HALT_LIMIT-1. A `quiet` seen at that same edge still gives good status.
- R10: A frame with `sr_vld`=1 and `sr_bit`=1 pre-empts any state other than reset-wait, and all outputs drop in the next cycle. The block then waits, ignoring `hw_rst_off` and `quiet`, until a frame with `sr_bit`=0 arrives. After that it runs the R8/R9 halt phase with a fresh `halt_strobe`.
- R11: Command strobes sampled outside idle, for example while a status is pending, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst_on | input | 1 | Hardware reset asserted |
| hw_rst_off | input | 1 | Hardware reset released |
| sr_vld | input | 1 | Control frame received this cycle |
| sr_bit | input | 1 | Software-reset bit of that frame |
| cmd_diag | input | 1 | Run-diagnostics command strobe |
| cmd_devrst | input | 1 | Device-reset command strobe |
| st_done | input | 1 | Self-test finished |
| st_pass | input | 1 | Self-test outcome, valid with st_done |
| quiet | input | 1 | Outstanding work has ceased |
| tx_ack | input | 1 | Transmit stub accepted the status frame |
| test_run | output | 1 | Self-test running |
| halt_strobe | output | 1 | One-cycle request to halt all outstanding work |
| tx_req | output | 1 | Status frame request |
| tx_stat | output | 8 | Status byte of the frame |
| tx_err | output | 8 | Error/diagnostic byte of the frame |
| idle_ret | output | 1 | One-cycle pulse on return to idle |

## Verification
A wrong state shows up at the ports within one cycle of the edge where it was taken. A missed pre-emption leaves `test_run` or `tx_req` high in the cycle after `hw_rst_on` or a software-reset frame. A wrong self-test branch shows as a flipped `tx_stat[0]` in the first `tx_req` cycle. An off-by-one in the halt timer moves the cycle where `tx_req` rises, or flips the outcome, when `quiet` arrives at halt edge HALT_LIMIT-1 or HALT_LIMIT. A command that leaks past idle shows up either as `test_run` or `halt_strobe` after the acknowledge, or as a missing `idle_ret`.

// File: rtl/dev_reset_seq_pkg.sv
package dev_reset_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_DIAG   = 3'd1,
        ST_GOOD   = 3'd2,
        ST_BAD    = 3'd3,
        ST_HALT   = 3'd4,
        ST_SRWAIT = 3'd5,
        ST_IDLE   = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic [7:0] stat;
        logic [7:0] err;
    } status_frame_t;

    localparam logic [7:0] STAT_OK   = 8'h50;
    localparam logic [7:0] STAT_FAIL = 8'h51;
    localparam logic [7:0] CODE_OK   = 8'h01;
    localparam logic [7:0] CODE_FAIL = 8'h80;

    function automatic status_frame_t make_frame(input logic ok);
        status_frame_t f;
        f.stat = ok ? STAT_OK : STAT_FAIL;
        f.err  = ok ? CODE_OK : CODE_FAIL;
        return f;
    endfunction

    function automatic logic is_sending(input seq_state_e s);
        return (s == ST_GOOD) || (s == ST_BAD);
    endfunction

endpackage

// File: rtl/dev_reset_seq_timer.sv
module dev_reset_seq_timer
    import dev_reset_seq_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expired
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Counts halt edges since entry; cleared whenever the halt phase is left.
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = active && (cnt == LAST);

endmodule

// File: rtl/dev_reset_seq_ctrl.sv
module dev_reset_seq_ctrl
    import dev_reset_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_on,
    input  logic       hw_off,
    input  logic       sr_set,
    input  logic       sr_clr,
    input  logic       go_diag,
    input  logic       go_reset,
    input  logic       test_done,
    input  logic       test_ok,
    input  logic       settled,
    input  logic       expired,
    input  logic       ack,
    output seq_state_e state,
    output logic       halt_entry,
    output logic       idle_entry
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        if (hw_on) begin
            nxt = ST_HOLD;
        end else if (sr_set && (state != ST_HOLD)) begin
            nxt = ST_SRWAIT;
        end else begin
            unique case (state)
                ST_HOLD:   if (hw_off) nxt = ST_DIAG;
                ST_DIAG:   if (test_done) nxt = test_ok ? ST_GOOD : ST_BAD;
                ST_GOOD,
                ST_BAD:    if (ack) nxt = ST_IDLE;
                ST_HALT: begin
                    if (settled)      nxt = ST_GOOD;
                    else if (expired) nxt = ST_BAD;
                end
                ST_SRWAIT: if (sr_clr) nxt = ST_HALT;
                ST_IDLE: begin
                    if (go_diag)       nxt = ST_DIAG;
                    else if (go_reset) nxt = ST_HALT;
                end
                default:   nxt = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HOLD;
            halt_entry <= 1'b0;
            idle_entry <= 1'b0;
        end else begin
            state      <= nxt;
            halt_entry <= (nxt == ST_HALT) && (state != ST_HALT);
            idle_entry <= (nxt == ST_IDLE) && (state != ST_IDLE);
        end
    end

endmodule

// File: rtl/dev_reset_seq_frame.sv
module dev_reset_seq_frame
    import dev_reset_seq_pkg::*;
(
    input  seq_state_e    state,
    output logic          req,
    output status_frame_t frame
);
    always_comb begin
        req   = is_sending(state);
        frame = '0;
        if (state == ST_GOOD) begin
            frame = make_frame(1'b1);
        end else if (state == ST_BAD) begin
            frame = make_frame(1'b0);
        end
    end
endmodule

// File: rtl/dev_reset_seq.sv
module dev_reset_seq
    import dev_reset_seq_pkg::*;
#(
    parameter int HALT_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_rst_on,
    input  logic       hw_rst_off,
    input  logic       sr_vld,
    input  logic       sr_bit,
    input  logic       cmd_diag,
    input  logic       cmd_devrst,
    input  logic       st_done,
    input  logic       st_pass,
    input  logic       quiet,
    input  logic       tx_ack,
    output logic       test_run,
    output logic       halt_strobe,
    output logic       tx_req,
    output logic [7:0] tx_stat,
    output logic [7:0] tx_err,
    output logic       idle_ret
);
    seq_state_e    state;
    status_frame_t frame;
    logic          expired;
    logic          sr_set;
    logic          sr_clr;

    assign sr_set = sr_vld && sr_bit;
    assign sr_clr = sr_vld && !sr_bit;

    dev_reset_seq_ctrl ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .hw_on      (hw_rst_on),
        .hw_off     (hw_rst_off),
        .sr_set     (sr_set),
        .sr_clr     (sr_clr),
        .go_diag    (cmd_diag),
        .go_reset   (cmd_devrst),
        .test_done  (st_done),
        .test_ok    (st_pass),
        .settled    (quiet),
        .expired    (expired),
        .ack        (tx_ack),
        .state      (state),
        .halt_entry (halt_strobe),
        .idle_entry (idle_ret)
    );

    dev_reset_seq_timer #(.LIMIT(HALT_LIMIT)) timer_i (
        .clk     (clk),
        .rst     (rst),
        .active  (state == ST_HALT),
        .expired (expired)
    );

    dev_reset_seq_frame frame_i (
        .state (state),
        .req   (tx_req),
        .frame (frame)
    );

    assign test_run = (state == ST_DIAG);
    assign tx_stat  = frame.stat;
    assign tx_err   = frame.err;

endmodule

// File: rtl/dev_reset_seq_chk.sv
module dev_reset_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       hw_rst_on,
    input logic       sr_vld,
    input logic       sr_bit,
    input logic       st_done,
    input logic       st_pass,
    input logic       tx_ack,
    input logic       test_run,
    input logic       halt_strobe,
    input logic       tx_req,
    input logic [7:0] tx_stat,
    input logic [7:0] tx_err,
    input logic       idle_ret
);
    p_hw_preempt_r2: assert property (@(posedge clk) disable iff (rst)
        hw_rst_on |=> (!tx_req && !test_run && !halt_strobe));

    p_diag_outcome_r4: assert property (@(posedge clk) disable iff (rst)
        (test_run && st_done && !hw_rst_on && !(sr_vld && sr_bit))
        |=> (tx_req && (tx_stat[0] == !$past(st_pass))));

    p_run_or_send_r4: assert property (@(posedge clk) disable iff (rst)
        !(tx_req && test_run));

    p_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> !tx_stat[7]);

    p_good_code_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_stat[0]) |-> (tx_err == 8'h01 && tx_stat == 8'h50));

    p_bad_code_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_stat[0]) |-> (tx_err == 8'h80 && tx_stat == 8'h51));

    p_hold_frame_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_ack && !hw_rst_on && !(sr_vld && sr_bit))
        |=> (tx_req && $stable(tx_stat) && $stable(tx_err)));

    p_ack_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_ack && !hw_rst_on && !(sr_vld && sr_bit))
        |=> (idle_ret && !tx_req));

    p_idle_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        idle_ret |=> !idle_ret);

    p_halt_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        halt_strobe |=> !halt_strobe);

    p_halt_quiet_outputs_r8: assert property (@(posedge clk) disable iff (rst)
        halt_strobe |-> (!tx_req && !test_run));

    p_sr_preempt_r10: assert property (@(posedge clk) disable iff (rst)
        (sr_vld && sr_bit && !hw_rst_on && (test_run || tx_req))
        |=> (!test_run && !tx_req && !halt_strobe));

endmodule

bind dev_reset_seq dev_reset_seq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .hw_rst_on   (hw_rst_on),
    .sr_vld      (sr_vld),
    .sr_bit      (sr_bit),
    .st_done     (st_done),
    .st_pass     (st_pass),
    .tx_ack      (tx_ack),
    .test_run    (test_run),
    .halt_strobe (halt_strobe),
    .tx_req      (tx_req),
    .tx_stat     (tx_stat),
    .tx_err      (tx_err),
    .idle_ret    (idle_ret)
);

// File: tb/dev_reset_seq_tb_top.sv
module dev_reset_seq_tb_top;
    localparam int LIMIT = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, hw_rst_on, hw_rst_off, sr_vld, sr_bit, cmd_diag, cmd_devrst;
    logic st_done, st_pass, quiet, tx_ack;
    logic test_run, halt_strobe, tx_req, idle_ret;
    logic [7:0] tx_stat, tx_err;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    dev_reset_seq #(.HALT_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst(rst), .hw_rst_on(hw_rst_on), .hw_rst_off(hw_rst_off),
        .sr_vld(sr_vld), .sr_bit(sr_bit), .cmd_diag(cmd_diag), .cmd_devrst(cmd_devrst),
        .st_done(st_done), .st_pass(st_pass), .quiet(quiet), .tx_ack(tx_ack),
        .test_run(test_run), .halt_strobe(halt_strobe), .tx_req(tx_req),
        .tx_stat(tx_stat), .tx_err(tx_err), .idle_ret(idle_ret)
    );

    // R5 encoding: {status, error code}
    function automatic logic [15:0] exp_frame(input bit pass);
        return pass ? 16'h5001 : 16'h5180;
    endfunction

    // R8/R9: halt edges until a status request, and its outcome
    function automatic int exp_halt_steps(input int d);
        return ((d < LIMIT - 1) ? d : LIMIT - 1) + 1;
    endfunction

    function automatic bit exp_halt_pass(input int d);
        return d < LIMIT;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_inputs();
        hw_rst_on = 0; hw_rst_off = 0; sr_vld = 0; sr_bit = 0;
        cmd_diag = 0; cmd_devrst = 0; st_done = 0; st_pass = 0;
        quiet = 0; tx_ack = 0;
    endtask

    task automatic finish_status(input bit pass, input int ackd);
        logic [15:0] f;
        chk("R4", tx_req, 1);
        chk("R5", {tx_stat, tx_err}, exp_frame(pass));
        f = {tx_stat, tx_err};
        for (int i = 0; i < ackd; i++) begin
            cyc(1);
            chk("R6", tx_req, 1);
            chk("R6", {tx_stat, tx_err}, f);
        end
        tx_ack = 1; cyc(1); tx_ack = 0;
        chk("R6", tx_req, 0);
        chk("R6", idle_ret, 1);
        cyc(1);
        chk("R6", idle_ret, 0);
    endtask

    task automatic run_diag(input bit pass, input int dly, input int ackd);
        for (int i = 0; i < dly; i++) begin
            chk("R4", test_run, 1);
            cyc(1);
        end
        st_done = 1; st_pass = pass; cyc(1); st_done = 0; st_pass = 0;
        chk("R4", test_run, 0);
        finish_status(pass, ackd);
    endtask

    task automatic start_diag();
        cmd_diag = 1; cyc(1); cmd_diag = 0;
        chk("R7", test_run, 1);
    endtask

    // Called in the first halt cycle (halt_strobe visible).
    task automatic run_halt(input int d, input int ackd);
        int n = 0;
        quiet = (d == 0);
        while (!tx_req && n < LIMIT + 4) begin
            cyc(1);
            n++;
            if (n == 1) chk("R8", halt_strobe, 0);
            quiet = (n >= d);
        end
        quiet = 0;
        chk(exp_halt_pass(d) ? "R8" : "R9", n, exp_halt_steps(d));
        finish_status(exp_halt_pass(d), ackd);
    endtask

    task automatic start_devrst();
        cmd_devrst = 1; cyc(1); cmd_devrst = 0;
        chk("R8", halt_strobe, 1);
        chk("R8", tx_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_inputs();
        rst = 1;
        cyc(3);
        chk("R1", {test_run, halt_strobe, tx_req, idle_ret}, 0);
        rst = 0;
        cyc(1);
        chk("R1", {test_run, halt_strobe, tx_req, idle_ret}, 0);

        // R3: stimulus other than release is ignored while waiting
        cmd_diag = 1; cmd_devrst = 1; sr_vld = 1; sr_bit = 1; quiet = 1;
        cyc(3);
        clear_inputs();
        cyc(1);
        chk("R3", {test_run, halt_strobe, tx_req, idle_ret}, 0);
        hw_rst_off = 1; cyc(1); hw_rst_off = 0;
        chk("R3", test_run, 1);
        run_diag(1, 3, 2);

        // R7: diag beats devrst when both strobe
        cmd_diag = 1; cmd_devrst = 1; cyc(1); cmd_diag = 0; cmd_devrst = 0;
        chk("R7", test_run, 1);
        chk("R7", halt_strobe, 0);
        // fail path, then R11: commands during pending status ignored
        st_done = 1; st_pass = 0; cyc(1); st_done = 0;
        chk("R4", {tx_stat, tx_err}, exp_frame(0));
        cmd_diag = 1; cmd_devrst = 1; cyc(1); cmd_diag = 0; cmd_devrst = 0;
        chk("R11", tx_req, 1);
        chk("R11", halt_strobe, 0);
        finish_status(0, 0);
        chk("R11", test_run, 0);

        // R8/R9 boundaries
        start_devrst(); run_halt(2, 1);
        start_devrst(); run_halt(LIMIT - 1, 0);
        start_devrst(); run_halt(LIMIT, 0);
        start_devrst(); run_halt(LIMIT + 3, 2);

        // R2: hardware reset during diagnostics
        start_diag();
        hw_rst_on = 1; cyc(1); hw_rst_on = 0;
        chk("R2", test_run, 0);
        cyc(3);
        chk("R2", {test_run, tx_req, halt_strobe}, 0);
        hw_rst_off = 1; cyc(1); hw_rst_off = 0;
        chk("R2", test_run, 1);
        run_diag(1, 0, 0);

        // R2: hardware reset during pending status
        start_diag();
        st_done = 1; st_pass = 0; cyc(1); st_done = 0;
        chk("R4", tx_req, 1);
        hw_rst_on = 1; cyc(1); hw_rst_on = 0;
        chk("R2", tx_req, 0);
        chk("R2", idle_ret, 0);
        hw_rst_off = 1; cyc(1); hw_rst_off = 0;
        run_diag(0, 1, 0);

        // R2: hardware reset during halt
        start_devrst();
        hw_rst_on = 1; quiet = 1; cyc(1); hw_rst_on = 0;
        cyc(1); quiet = 0;
        chk("R2", {test_run, tx_req, halt_strobe}, 0);
        hw_rst_off = 1; cyc(1); hw_rst_off = 0;
        chk("R2", test_run, 1);
        run_diag(1, 1, 0);

        // R10: software reset pre-empts diagnostics, waits for clear bit
        start_diag();
        sr_vld = 1; sr_bit = 1; cyc(1); sr_vld = 0; sr_bit = 0;
        chk("R10", test_run, 0);
        quiet = 1; hw_rst_off = 1; cyc(3); quiet = 0; hw_rst_off = 0;
        chk("R10", {test_run, tx_req, halt_strobe}, 0);
        sr_vld = 1; sr_bit = 0; cyc(1); sr_vld = 0;
        chk("R10", halt_strobe, 1);
        run_halt(1, 0);

        // R10: software reset pre-empts a pending status
        start_devrst(); quiet = 1; cyc(1); quiet = 0;
        chk("R8", tx_req, 1);
        sr_vld = 1; sr_bit = 1; cyc(1); sr_vld = 0; sr_bit = 0;
        chk("R10", {tx_req, idle_ret}, 0);
        sr_vld = 1; sr_bit = 0; cyc(1); sr_vld = 0;
        chk("R10", halt_strobe, 1);
        run_halt(LIMIT + 1, 0);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int op   = $urandom_range(0, 1);
            bit pass = 1'($urandom_range(0, 1));
            int dly  = $urandom_range(0, 5);
            int ackd = $urandom_range(0, 3);
            int d    = $urandom_range(0, LIMIT + 2);
            if (op == 0) begin
                start_diag();
                run_diag(pass, dly, ackd);
            end else begin
                start_devrst();
                run_halt(d, ackd);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule